// File: doc/BRIEF.md
# Pixel Output Blanking Pipeline

This block is the last stage of a 10-bit image digitizer. On every rising edge of the pixel data clock it takes one converted sample. It returns that sample on a registered output bus after a fixed latency of nine data-clock cycles. The block does not alter the sample value, except when the sample is blanked.

A pre-blanking input marks samples whose output must read as all zeros. Two clamp-window inputs also exist: one for the optical-black window and one for the dummy window. If either window is active in the same cycle as pre-blanking, the clamp takes precedence and that sample is delivered unchanged. The blank decision is formed in the same cycle the sample is captured. It then moves down a flag pipeline that runs alongside the data, so a change on the blanking input affects only the samples captured while the change is present.

An active-low synchronous reset clears every stage. A valid strobe rises once the pipeline holds nine samples captured after reset release.

Top module: `pix_blank_pipe`

## Requirements
- R1: All 10 sample bits pass through unchanged and in place, with bit 9 as the MSB and bit 0 as the LSB.
- R2: A sample captured at a clock edge with pre-blanking low is on `pixOut` from the eighth following edge onward. It is therefore visible for the ninth cycle after the cycle in which it was presented.
- R3: A sample captured with `preBlank` high and both clamp windows low is delivered as 10'h000.
- R4: A sample captured with `preBlank` high while `clampOb` or `clampDummy` is high is delivered unchanged.
- R5: With `preBlank` held low, every sample is delivered unchanged, whatever values the samples take.
- R6: The blank decision follows its own sample. Toggling `preBlank` every cycle blanks exactly the samples captured while it was high.
- R7: While `rstN` is low at a clock edge, all stages clear. `pixOut` reads 10'h000 until a sample captured after release reaches the output.
- R8: `pixValid` is low during reset. It rises at the ninth clock edge with `rstN` high after release and stays high until the next reset.
- R9: With `preBlank` low, either clamp window alone has no effect on the delivered data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel data clock |
| rstN | input | 1 | Synchronous reset, active low |
| pixIn | input | 10 | Converted sample for this cycle |
| preBlank | input | 1 | Force this sample to zero at the output |
| clampOb | input | 1 | Optical-black clamp window active |
| clampDummy | input | 1 | Dummy clamp window active |
| pixOut | output | 10 | Registered delayed sample |
| pixValid | output | 1 | Pipeline holds samples captured since reset |

## Verification
A flag stage that slips against its data stage shows up as blanking that lands on the neighbour of the intended sample. The alternating blanking pattern exposes this on the first output of that pattern, nine cycles after the stimulus. A data stage lost or duplicated moves every sample by one cycle, so the first checked output after fill already differs. A wrong fill count shows as `pixValid` rising one or more edges early or late after each reset release. The mid-stream reset exercises this a second time.

// File: rtl/pix_blank_pkg.sv
package pix_blank_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic blankNow;   // blank decision for the sample captured this edge
    logic pipeFull;   // all stages hold post-reset samples
  } ctrlStrobes_t;
endpackage

// File: rtl/pix_blank_ctrl.sv
module pix_blank_ctrl
  import pix_blank_pkg::*;
#(
  parameter int LATENCY = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         preBlank,
  input  logic         clampOb,
  input  logic         clampDummy,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LATENCY);

  logic [CNT_W-1:0] fillCnt;
  logic clampAny;

  assign clampAny = clampOb | clampDummy;

  always_ff @(posedge clk) begin
    if (!rstN) fillCnt <= '0;
    else if (fillCnt != FULL_CNT) fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    strobes.blankNow = preBlank & ~clampAny;
    strobes.pipeFull = (fillCnt == FULL_CNT);
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FULL_CNT);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pipeFull |=> strobes.pipeFull);
endmodule

// File: rtl/pix_blank_dp.sv
module pix_blank_dp
  import pix_blank_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixIn,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] pixOut
);
  localparam int NSTAGE = LATENCY - 1;  // stages ahead of the output register

  logic [DATA_W-1:0] dataPipe [NSTAGE];
  logic [NSTAGE-1:0] flagPipe;
  logic [DATA_W-1:0] outQ;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataPipe[g] <= '0;
          flagPipe[g] <= 1'b0;
        end else begin
          dataPipe[g] <= pixIn;
          flagPipe[g] <= strobes.blankNow;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataPipe[g] <= '0;
          flagPipe[g] <= 1'b0;
        end else begin
          dataPipe[g] <= dataPipe[g-1];
          flagPipe[g] <= flagPipe[g-1];
        end
      end
      p_stage_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (dataPipe[g] == $past(dataPipe[g-1])) && (flagPipe[g] == $past(flagPipe[g-1])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outQ <= '0;
    else outQ <= flagPipe[NSTAGE-1] ? '0 : dataPipe[NSTAGE-1];
  end

  assign pixOut = outQ;

  p_blank_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(flagPipe[NSTAGE-1])) |-> (pixOut == '0));
  p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(flagPipe[NSTAGE-1])) |-> (pixOut == $past(dataPipe[NSTAGE-1])));
endmodule

// File: rtl/pix_blank_pipe.sv
module pix_blank_pipe
  import pix_blank_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixIn,
  input  logic              preBlank,
  input  logic              clampOb,
  input  logic              clampDummy,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid
);
  ctrlStrobes_t strobes;

  pix_blank_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .preBlank(preBlank),
    .clampOb(clampOb), .clampDummy(clampDummy), .strobes(strobes)
  );

  pix_blank_dp #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_dp (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .strobes(strobes), .pixOut(pixOut)
  );

  assign pixValid = strobes.pipeFull;

  p_clamp_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clampOb || clampDummy) |=> !u_dp.flagPipe[0]);
  p_blank_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    (preBlank && !clampOb && !clampDummy) |=> u_dp.flagPipe[0]);
  p_not_full_in_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !pixValid);
endmodule

// File: tb/pix_blank_pipe_tb.sv
module pix_blank_pipe_tb;
  localparam int LAT = 9;
  localparam int HMAX = 512;
  // {data[13:4], preBlank, clampOb, clampDummy, expectZero}
  localparam logic [13:0] VEC [12] = '{
    {10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'h200, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'h001, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'h155, 1'b1, 1'b0, 1'b0, 1'b1},
    {10'h2AA, 1'b1, 1'b0, 1'b0, 1'b1},
    {10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0},
    {10'h123, 1'b1, 1'b0, 1'b1, 1'b0},
    {10'h0F0, 1'b1, 1'b1, 1'b1, 1'b0},
    {10'h30F, 1'b0, 1'b1, 1'b0, 1'b0},
    {10'h0AB, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'h3C3, 1'b1, 1'b0, 1'b0, 1'b1},
    {10'h05A, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] pixIn = '0;
  logic preBlank = 1'b0, clampOb = 1'b0, clampDummy = 1'b0;
  logic [9:0] pixOut;
  logic pixValid;

  int compared = 0;
  int mismatched = 0;
  int idx = 0;
  int cycles = 0;
  logic [9:0] histD [HMAX];
  logic histZ [HMAX];
  logic histR [HMAX];
  string histTag [HMAX];

  always #2.5 clk = ~clk;

  pix_blank_pipe u_dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .preBlank(preBlank),
    .clampOb(clampOb), .clampDummy(clampDummy),
    .pixOut(pixOut), .pixValid(pixValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic checkNow();
    int j = idx - LAT;
    logic expV = (j >= 0);
    logic [9:0] expD;
    string tag;
    if (expV) for (int k = j; k < idx; k++) if (!histR[k]) expV = 1'b0;
    expD = (expV && !histZ[j]) ? histD[j] : 10'h000;
    tag = expV ? histTag[j] : "R7";
    compared++;
    if (pixOut !== expD) begin
      mismatched++;
      $display("FAIL %s: pixOut actual %h expected %h (step %0d)", tag, pixOut, expD, idx);
    end
    compared++;
    if (pixValid !== expV) begin
      mismatched++;
      $display("FAIL R8: pixValid actual %b expected %b (step %0d)", pixValid, expV, idx);
    end
  endtask

  task automatic step(input logic [9:0] d, input logic p, input logic o, input logic m,
                      input logic r, input logic z, input string tag);
    @(negedge clk);
    checkNow();
    pixIn = d; preBlank = p; clampOb = o; clampDummy = m; rstN = r;
    histD[idx] = d; histZ[idx] = z; histR[idx] = r; histTag[idx] = tag;
    idx++;
  endtask

  function automatic string tableTag(input logic p, input logic o, input logic m, input logic z);
    if (z) return "R3";
    if (p && (o || m)) return "R4";
    if (o || m) return "R9";
    return "R1 R2";
  endfunction

  initial begin
    // reset held: outputs clear, valid low (R7, R8)
    for (int i = 0; i < 4; i++) step(10'h3A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    // vector table
    for (int i = 0; i < 12; i++) begin
      logic [13:0] v = VEC[i];
      step(v[13:4], v[3], v[2], v[1], 1'b1, v[0], tableTag(v[3], v[2], v[1], v[0]));
    end
    // R6: blank toggles every cycle, each decision stays with its sample
    for (int i = 0; i < 12; i++)
      step(10'(10'h040 + i * 37), i[0], 1'b0, 1'b0, 1'b1, i[0], "R6");
    // R5: preBlank tied low, walking-one and ramp data
    for (int i = 0; i < 20; i++)
      step((i < 10) ? (10'h001 << i) : 10'(i * 53), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // mid-stream reset (R7) then refill (R8)
    for (int i = 0; i < 3; i++) step(10'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 12; i++)
      step(10'(10'h2F0 + i), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    // drain
    for (int i = 0; i < 10; i++) step(10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule